// File: doc/BRIEF.md
# Control Register Access Unit

This block executes the six control-register access instructions of a 32-bit integer core against a small local bank of control and status registers. Each cycle it may receive one instruction word, together with the value already read from the source register and the current privilege level. Within the same cycle it returns the register's previous contents for the destination register, a write-back enable, and one strobe each for read and write side effects. It also raises an illegal-instruction flag when the access is not allowed. If the access performs a write, the new register contents take effect at the next rising clock edge.

There are three operations: replace, set bits and clear bits. Each comes in two forms. The register form takes its operand from the source-register value. The immediate form takes its operand from the 5-bit source field itself. A zero destination field or a zero source field can suppress either the read or the write, depending on the operation. The legality checks take those suppressions into account. As a result, a pure read of a read-only register is permitted. The pipeline, the register file, trap entry and interrupt handling are outside this block.

Top module: `csr_access_unit`

## Requirements
- R1: An instruction is handled only when `instr_valid` is 1, bits 6..0 equal 1110011, and bits 14..12 are one of 001 (replace), 010 (set), 011 (clear), 101 (replace-immediate), 110 (set-immediate) or 111 (clear-immediate). In every other case all outputs are zero and no register changes.
- R2: The register address is taken from bits 31..20, the source field from bits 19..15 and the destination field from bits 11..7. When a read takes place, `rd_data` carries the register's previous value and `rd_we` is 1. Otherwise both are zero.
- R3: Replace writes the operand into the register. Set ORs the operand into it. Clear zeroes each bit where the operand has a 1. In all three cases only the register's writable bits change, and the result is visible from the next clock edge onward.
- R4: The immediate forms use the 5-bit source field, zero-extended, as the operand and ignore `rs1_value`.
- R5: For set and clear in either form, a zero source field causes no write and leaves `wr_strobe` at 0. The read and `rd_strobe` still occur.
- R6: For replace in either form, a zero destination field causes no read: `rd_strobe`, `rd_we` and `rd_data` are all 0. The write still happens. For set and clear, a zero destination field still reads.
- R7: An address that is not one of the implemented registers raises `illegal`.
- R8: Privilege levels are 00 user, 01 supervisor and 11 machine. An access raises `illegal` when `cur_priv` is below address bits 9..8.
- R9: An address whose bits 11..10 are 11 is read-only. A write that actually occurs to such an address raises `illegal`. A read whose write is suppressed does not raise it.
- R10: While `illegal` is 1, `rd_we`, `rd_data`, `rd_strobe` and `wr_strobe` are all 0, and no register changes.
- R11: A synchronous active-high `rst` loads every register with its reset value. Register contents change only at a clock edge that follows a legal access which performs a write.
- R12: The implemented registers are listed here as address / writable mask / reset value: 0x300 / 0x0000188A / 0x00001800; 0x340 / 0xFFFFFFFF / 0; 0x344 / 0x00000AAA / 0; 0x140 / 0xFFFFFFFF / 0; 0x040 / 0x000000FF / 0; 0xF11 / 0 / 0x5A5A0001; 0xC01 / 0 / 0x00000123.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| rs1_value | input | XLEN | Value of the source register |
| cur_priv | input | 2 | Current privilege level |
| rd_data | output | XLEN | Previous register value for the destination register |
| rd_we | output | 1 | Destination write-back enable |
| illegal | output | 1 | Illegal-instruction flag |
| rd_strobe | output | 1 | Read side-effect strobe |
| wr_strobe | output | 1 | Write side-effect strobe |

## Verification
The read of the old value and the commit of the new value belong to the same instruction and fall in the same cycle. `rd_data` must show the value from before the write, while the register takes the new value at the edge that closes that cycle. The bench provokes this with back-to-back replace, set and clear instructions to one register. Each result is judged against a behavioural model whose state is updated only after that edge, so the following instruction must return exactly the value the previous one produced. A second same-cycle pairing is the legality check together with write suppression. Read-only and privilege-restricted addresses are accessed with and without a zero source or destination field, and the bench checks the flag and the strobes together.

// File: rtl/csr_pkg.sv
package csr_pkg;

  localparam int XLEN = 32;
  localparam int ILEN = 32;
  localparam int NCSR = 7;

  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  typedef logic [11:0] csr_addr_t;

  typedef struct packed {
    logic      active;
    csr_op_e   op;
    logic      use_imm;
    logic      do_read;
    logic      do_write;
    csr_addr_t addr;
    logic [4:0] src;
    logic [4:0] dst;
  } csr_dec_t;

  localparam csr_addr_t CSR_ADDR [NCSR] = '{
    12'h300, 12'h340, 12'h344, 12'h140, 12'h040, 12'hF11, 12'hC01
  };

  localparam logic [XLEN-1:0] CSR_WMASK [NCSR] = '{
    32'h0000_188A, 32'hFFFF_FFFF, 32'h0000_0AAA, 32'hFFFF_FFFF,
    32'h0000_00FF, 32'h0000_0000, 32'h0000_0000
  };

  localparam logic [XLEN-1:0] CSR_RESET [NCSR] = '{
    32'h0000_1800, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
    32'h0000_0000, 32'h5A5A_0001, 32'h0000_0123
  };

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
#(
  parameter int ILEN = csr_pkg::ILEN
) (
  input  logic            valid_i,
  input  logic [ILEN-1:0] instr_i,
  output csr_dec_t        dec_o
);

  logic [2:0] funct3;
  logic       opc_hit;

  assign funct3  = instr_i[14:12];
  assign opc_hit = (instr_i[6:0] == OPC_SYSTEM);

  always_comb begin
    dec_o.addr    = instr_i[31:20];
    dec_o.src     = instr_i[19:15];
    dec_o.dst     = instr_i[11:7];
    dec_o.op      = csr_op_e'(funct3[1:0]);
    dec_o.use_imm = funct3[2];
    dec_o.active  = valid_i && opc_hit && (funct3[1:0] != 2'b00);
    // replace always writes; set/clear write only with a nonzero source
    dec_o.do_write = (dec_o.op == OP_WRITE) || (dec_o.src != 5'd0);
    // replace reads only with a nonzero destination; set/clear always read
    dec_o.do_read  = (dec_o.op != OP_WRITE) || (dec_o.dst != 5'd0);
  end

endmodule

// File: rtl/csr_update.sv
module csr_update
  import csr_pkg::*;
#(
  parameter int XLEN = csr_pkg::XLEN
) (
  input  csr_op_e         op_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] operand_i,
  output logic [XLEN-1:0] new_o
);

  always_comb begin
    unique case (op_i)
      OP_WRITE: new_o = operand_i;
      OP_SET:   new_o = old_i | operand_i;
      OP_CLEAR: new_o = old_i & ~operand_i;
      default:  new_o = old_i;
    endcase
  end

endmodule

// File: rtl/csr_file.sv
module csr_file
  import csr_pkg::*;
#(
  parameter int XLEN = csr_pkg::XLEN,
  parameter int NCSR = csr_pkg::NCSR
) (
  input  logic                 clk,
  input  logic                 rst,
  input  csr_addr_t            addr_i,
  input  logic                 wr_en_i,
  input  logic [XLEN-1:0]      wr_data_i,
  output logic                 hit_o,
  output logic [XLEN-1:0]      rd_data_o,
  output logic [NCSR*XLEN-1:0] state_o
);

  logic [NCSR-1:0] sel;
  logic [XLEN-1:0] val [NCSR];

  for (genvar i = 0; i < NCSR; i++) begin : g_csr
    localparam logic [XLEN-1:0] WMASK = CSR_WMASK[i];
    localparam logic [XLEN-1:0] RSTV  = CSR_RESET[i];

    assign sel[i] = (addr_i == CSR_ADDR[i]);

    if (WMASK == '0) begin : g_const
      assign val[i] = RSTV;
    end else begin : g_reg
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= RSTV;
        end else if (wr_en_i && sel[i]) begin
          q <= (q & ~WMASK) | (wr_data_i & WMASK);
        end
      end
      assign val[i] = q;
    end

    assign state_o[i*XLEN +: XLEN] = val[i];
  end

  always_comb begin
    hit_o     = 1'b0;
    rd_data_o = '0;
    for (int i = 0; i < NCSR; i++) begin
      if (sel[i]) begin
        hit_o     = 1'b1;
        rd_data_o = rd_data_o | val[i];
      end
    end
  end

endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_pkg::*;
#(
  parameter int XLEN = csr_pkg::XLEN,
  parameter int ILEN = csr_pkg::ILEN,
  parameter int NCSR = csr_pkg::NCSR
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid,
  input  logic [ILEN-1:0] instr,
  input  logic [XLEN-1:0] rs1_value,
  input  logic [1:0]      cur_priv,
  output logic [XLEN-1:0] rd_data,
  output logic            rd_we,
  output logic            illegal,
  output logic            rd_strobe,
  output logic            wr_strobe
);

  localparam int IMMW = 5;

  csr_dec_t              dec;
  logic                  hit;
  logic [XLEN-1:0]       old_val;
  logic [XLEN-1:0]       new_val;
  logic [XLEN-1:0]       operand;
  logic [NCSR*XLEN-1:0]  csr_state;
  logic                  read_only;
  logic                  priv_ok;
  logic                  bad;
  logic                  ok;

  csr_decode #(.ILEN(ILEN)) u_dec (
    .valid_i (instr_valid),
    .instr_i (instr),
    .dec_o   (dec)
  );

  assign operand = dec.use_imm ? {{(XLEN-IMMW){1'b0}}, dec.src} : rs1_value;

  csr_update #(.XLEN(XLEN)) u_upd (
    .op_i      (dec.op),
    .old_i     (old_val),
    .operand_i (operand),
    .new_o     (new_val)
  );

  assign read_only = (dec.addr[11:10] == 2'b11);
  assign priv_ok   = (cur_priv >= dec.addr[9:8]);
  assign bad       = !hit || !priv_ok || (read_only && dec.do_write);
  assign ok        = dec.active && !bad;

  assign illegal   = dec.active && bad;
  assign rd_strobe = ok && dec.do_read;
  assign wr_strobe = ok && dec.do_write;
  assign rd_we     = rd_strobe;
  assign rd_data   = rd_strobe ? old_val : '0;

  csr_file #(.XLEN(XLEN), .NCSR(NCSR)) u_file (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (dec.addr),
    .wr_en_i   (wr_strobe),
    .wr_data_i (new_val),
    .hit_o     (hit),
    .rd_data_o (old_val),
    .state_o   (csr_state)
  );

endmodule

// File: rtl/csr_access_unit_chk.sv
module csr_access_unit_chk #(
  parameter int XLEN = 32,
  parameter int ILEN = 32,
  parameter int NCSR = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 instr_valid,
  input logic [ILEN-1:0]      instr,
  input logic [1:0]           cur_priv,
  input logic [XLEN-1:0]      rd_data,
  input logic                 rd_we,
  input logic                 illegal,
  input logic                 rd_strobe,
  input logic                 wr_strobe,
  input logic [NCSR*XLEN-1:0] csr_state
);

  logic sys_op;
  assign sys_op = instr_valid && (instr[6:0] == 7'b1110011);

  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!rd_we && !rd_strobe && !wr_strobe && rd_data == '0)); // R10

  AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    illegal |=> $stable(csr_state)); // R10

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_strobe |=> $stable(csr_state)); // R11

  AST_SETCLR_ZERO_SRC: assert property (@(posedge clk) disable iff (rst)
    (sys_op && instr[13] && instr[19:15] == 5'd0) |-> !wr_strobe); // R5

  AST_REPLACE_ZERO_DST: assert property (@(posedge clk) disable iff (rst)
    (sys_op && instr[13:12] == 2'b01 && instr[11:7] == 5'd0) |-> (!rd_strobe && !rd_we)); // R6

  AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> (instr[31:30] != 2'b11)); // R9

  AST_PRIV_GATE: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe || wr_strobe) |-> (cur_priv >= instr[29:28])); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> (!illegal && !rd_strobe && !wr_strobe && rd_data == '0)); // R1

  AST_NO_READ_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    !rd_we |-> (rd_data == '0)); // R2

endmodule

bind csr_access_unit csr_access_unit_chk #(.XLEN(XLEN), .ILEN(ILEN), .NCSR(NCSR)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr       (instr),
  .cur_priv    (cur_priv),
  .rd_data     (rd_data),
  .rd_we       (rd_we),
  .illegal     (illegal),
  .rd_strobe   (rd_strobe),
  .wr_strobe   (wr_strobe),
  .csr_state   (csr_state)
);

// File: tb/sim_csr_access_unit.sv
module sim_csr_access_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [31:0] instr;
  logic [31:0] rs1_value;
  logic [1:0]  cur_priv;
  logic [31:0] rd_data;
  logic        rd_we, illegal, rd_strobe, wr_strobe;

  always #2 clk = ~clk;

  csr_access_unit u0 (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .rs1_value(rs1_value), .cur_priv(cur_priv), .rd_data(rd_data),
    .rd_we(rd_we), .illegal(illegal), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // reference register table, written from R12
  logic [11:0] m_addr [7] = '{12'h300, 12'h340, 12'h344, 12'h140, 12'h040, 12'hF11, 12'hC01};
  logic [31:0] m_mask [7] = '{32'h188A, 32'hFFFFFFFF, 32'hAAA, 32'hFFFFFFFF, 32'hFF, 32'h0, 32'h0};
  logic [31:0] m_rst  [7] = '{32'h1800, 32'h0, 32'h0, 32'h0, 32'h0, 32'h5A5A0001, 32'h123};
  logic [31:0] m_val  [7];

  localparam logic [6:0] SYS = 7'b1110011;
  localparam logic [1:0] PU = 2'b00, PS = 2'b01, PM = 2'b11;

  function automatic int find_csr(logic [11:0] a);
    for (int i = 0; i < 7; i++) if (m_addr[i] == a) return i;
    return -1;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 7; i++) m_val[i] = m_rst[i];
  endtask

  task automatic op(string tag, logic v, logic [6:0] opc, logic [2:0] f3, logic [11:0] a,
                    logic [4:0] s, logic [4:0] d, logic [31:0] r1, logic [1:0] pv);
    logic        active, dw, dr, bad, ok, e_ill, e_rs, e_ws;
    logic [31:0] opnd, e_rd, nv;
    int          idx;
    @(negedge clk);
    instr_valid = v;
    instr       = {a, s, f3, d, opc};
    rs1_value   = r1;
    cur_priv    = pv;
    #1;
    active = v && (opc == SYS) && (f3[1:0] != 2'b00);
    opnd   = f3[2] ? {27'd0, s} : r1;
    dw     = (f3[1:0] == 2'b01) || (s != 5'd0);
    dr     = (f3[1:0] != 2'b01) || (d != 5'd0);
    idx    = find_csr(a);
    bad    = (idx < 0) || (pv < a[9:8]) || ((a[11:10] == 2'b11) && dw);
    e_ill  = active && bad;
    ok     = active && !bad;
    e_rs   = ok && dr;
    e_ws   = ok && dw;
    e_rd   = (e_rs && idx >= 0) ? m_val[idx] : 32'd0;
    nv     = 32'd0;
    if (ok && idx >= 0) begin
      case (f3[1:0])
        2'b01:   nv = opnd;
        2'b10:   nv = m_val[idx] | opnd;
        default: nv = m_val[idx] & ~opnd;
      endcase
    end
    chk(tag, "rd_data",   rd_data,   e_rd);
    chk(tag, "rd_we",     {31'd0, rd_we},     {31'd0, e_rs});
    chk(tag, "illegal",   {31'd0, illegal},   {31'd0, e_ill});
    chk(tag, "rd_strobe", {31'd0, rd_strobe}, {31'd0, e_rs});
    chk(tag, "wr_strobe", {31'd0, wr_strobe}, {31'd0, e_ws});
    @(posedge clk);
    if (e_ws && idx >= 0) m_val[idx] = (m_val[idx] & ~m_mask[idx]) | (nv & m_mask[idx]);
    #0;
  endtask

  // plain read through set-bits with zero source
  task automatic rd(string tag, logic [11:0] a, logic [1:0] pv);
    op(tag, 1'b1, SYS, 3'b010, a, 5'd0, 5'd1, 32'hFFFF_FFFF, pv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; instr_valid = 1'b0; instr = 32'd0; rs1_value = 32'd0; cur_priv = PM;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R11", "reset rd_data",  rd_data, 32'd0);
    chk("R11", "reset strobes",  {29'd0, illegal, rd_strobe, wr_strobe}, 32'd0);
    rst = 1'b0;

    // R12 / R11: reset contents of every register
    for (int i = 0; i < 7; i++) rd("R12", m_addr[i], PM);

    // R3: read-old / write-new back to back on one register
    op("R3", 1'b1, SYS, 3'b001, 12'h340, 5'd3, 5'd5, 32'hDEADBEEF, PM);
    op("R3", 1'b1, SYS, 3'b010, 12'h340, 5'd2, 5'd5, 32'h000000F0, PM);
    op("R3", 1'b1, SYS, 3'b011, 12'h340, 5'd2, 5'd5, 32'hFFFF0000, PM);
    rd("R3", 12'h340, PM);
    // R3: writable mask limits the change
    op("R3", 1'b1, SYS, 3'b001, 12'h300, 5'd4, 5'd6, 32'hFFFFFFFF, PM);
    op("R3", 1'b1, SYS, 3'b011, 12'h300, 5'd4, 5'd6, 32'hFFFFFFFF, PM);
    op("R3", 1'b1, SYS, 3'b010, 12'h344, 5'd4, 5'd6, 32'hFFFFFFFF, PM);
    op("R3", 1'b1, SYS, 3'b011, 12'h344, 5'd4, 5'd6, 32'h0000000A, PM);
    rd("R3", 12'h344, PM);

    // R4: immediate forms ignore rs1_value
    op("R4", 1'b1, SYS, 3'b101, 12'h040, 5'h1F, 5'd7, 32'hFFFF0000, PM);
    op("R4", 1'b1, SYS, 3'b111, 12'h040, 5'h05, 5'd7, 32'hFFFFFFFF, PM);
    op("R4", 1'b1, SYS, 3'b110, 12'h040, 5'h00, 5'd7, 32'hFFFFFFFF, PM);
    op("R4", 1'b1, SYS, 3'b110, 12'h340, 5'h10, 5'd7, 32'h0, PM);
    rd("R4", 12'h040, PM);

    // R5: zero source suppresses the write but not the read
    op("R5", 1'b1, SYS, 3'b011, 12'h340, 5'd0, 5'd8, 32'hFFFFFFFF, PM);
    op("R5", 1'b1, SYS, 3'b010, 12'h140, 5'd0, 5'd8, 32'hFFFFFFFF, PM);
    op("R5", 1'b1, SYS, 3'b111, 12'h344, 5'd0, 5'd8, 32'hFFFFFFFF, PM);
    rd("R5", 12'h340, PM);

    // R6: zero destination
    op("R6", 1'b1, SYS, 3'b001, 12'h140, 5'd9, 5'd0, 32'h12345678, PM);
    op("R6", 1'b1, SYS, 3'b101, 12'h040, 5'd3, 5'd0, 32'h0, PM);
    op("R6", 1'b1, SYS, 3'b011, 12'h140, 5'd9, 5'd0, 32'h0000FFFF, PM);
    rd("R6", 12'h140, PM);
    rd("R6", 12'h040, PM);

    // R7: unimplemented address
    op("R7", 1'b1, SYS, 3'b010, 12'h7C0, 5'd0, 5'd1, 32'h0, PM);
    op("R7", 1'b1, SYS, 3'b001, 12'h341, 5'd1, 5'd1, 32'h55, PM);

    // R8: privilege
    op("R8", 1'b1, SYS, 3'b001, 12'h340, 5'd1, 5'd1, 32'hAAAA5555, PU);
    op("R8", 1'b1, SYS, 3'b010, 12'h140, 5'd0, 5'd1, 32'h0, PU);
    op("R8", 1'b1, SYS, 3'b010, 12'h140, 5'd1, 5'd1, 32'h00F00000, PS);
    op("R8", 1'b1, SYS, 3'b101, 12'h040, 5'd9, 5'd1, 32'h0, PU);
    op("R8", 1'b1, SYS, 3'b010, 12'hF11, 5'd0, 5'd1, 32'h0, PS);
    rd("R8", 12'h340, PM);
    rd("R8", 12'h140, PS);

    // R9: read-only registers
    rd("R9", 12'hF11, PM);
    rd("R9", 12'hC01, PU);
    op("R9", 1'b1, SYS, 3'b111, 12'hC01, 5'd0, 5'd2, 32'h0, PU);
    op("R9", 1'b1, SYS, 3'b001, 12'hF11, 5'd1, 5'd0, 32'h1, PM);
    op("R9", 1'b1, SYS, 3'b111, 12'hC01, 5'd3, 5'd2, 32'h0, PM);
    op("R9", 1'b1, SYS, 3'b011, 12'hF11, 5'd4, 5'd2, 32'hFFFFFFFF, PM);

    // R10: illegal attempts leave contents untouched
    op("R10", 1'b1, SYS, 3'b001, 12'h344, 5'd1, 5'd3, 32'hFFFFFFFF, PS);
    rd("R10", 12'h344, PM);

    // R1: not handled
    op("R1", 1'b1, 7'b0110011, 3'b001, 12'h340, 5'd1, 5'd1, 32'h1, PM);
    op("R1", 1'b1, SYS, 3'b000, 12'h340, 5'd1, 5'd1, 32'h1, PM);
    op("R1", 1'b1, SYS, 3'b100, 12'h340, 5'd1, 5'd1, 32'h1, PM);
    op("R1", 1'b0, SYS, 3'b001, 12'h340, 5'd1, 5'd1, 32'h77, PM);
    rd("R1", 12'h340, PM);

    // R2: field positions, distinct registers in turn
    op("R2", 1'b1, SYS, 3'b001, 12'h340, 5'd31, 5'd31, 32'h0BADF00D, PM);
    op("R2", 1'b1, SYS, 3'b001, 12'h140, 5'd31, 5'd17, 32'h600DCAFE, PM);
    rd("R2", 12'h340, PM);
    rd("R2", 12'h140, PM);

    // R11: reset in the middle of a run
    @(negedge clk); instr_valid = 1'b0; rst = 1'b1;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 5; i++) rd("R11", m_addr[i], PM);

    @(negedge clk); instr_valid = 1'b0;
    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule